// File: doc/BRIEF.md
# Keyed Write-Protected Byte Store Controller

This block puts a 256-byte storage array behind a four-register CPU bus and makes it behave like nonvolatile memory. Software selects a byte through an address register and reads it by setting a request bit in the control register. The byte arrives in the data register one cycle later and stays there.

Writing is deliberately awkward. A write enable bit must already be set. The key register must then receive the byte 55h and after it the byte AAh. Only the next bus action, which sets the write bit, starts a program cycle. That cycle lasts a parameterised number of clocks. During it the address, data and control registers refuse bus writes. When it ends, the array takes the held byte, the write bit drops and a sticky completion flag drives the interrupt output. This guards the contents against runaway code.

Top module: `keyed_nvm_ctrl`

## Requirements
- R1: After reset the address, data and control registers read 00h, the key register reads 00h and `done_irq` is 0. The register offsets are 0 address, 1 data, 2 control and 3 key. The control bits are bit0 read request, bit1 write busy, bit2 write enable and bit3 completion flag.
- R2: A control write with bit0 = 1, made while no program cycle runs, loads the data register from the array at the current address. The value is visible from the next cycle. Bit0 always reads back as 0.
- R3: The data register keeps its value until another read request or a bus write to offset 1, even if the address register changes.
- R4: A program cycle starts only when three bus writes come in this order: 55h to offset 3, then AAh to offset 3, then a control write with bit1 = 1. Each byte needs the whole sequence again, and the key register always reads 00h.
- R5: A key write with any value other than the one expected next cancels the sequence. A bus write to offsets 0, 1 or 2 also cancels it.
- R6: Setting bit1 starts nothing unless bit2 was already 1 before that write. A single write that sets bit1 and bit2 together starts nothing, although it does set bit2.
- R7: Bit2 changes only through control writes. It is still set after a program cycle completes.
- R8: While a program cycle runs, bus writes to offsets 0, 1 and 2 have no effect, and read requests are ignored.
- R9: Bit1 reads 1 for exactly WRITE_CYCLES cycles, 16 by default. At the end the array byte at the address register takes the data register's value.
- R10: When a program cycle ends, bit3 and `done_irq` go to 1. They stay at 1 until a control write with bit3 = 0. A control write with bit3 = 1 leaves the flag as it is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe, one per cycle |
| bus_addr | input | 2 | Register offset for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data of the register at `bus_addr` |
| done_irq | output | 1 | Program-cycle completion flag |

## Verification
Every register write takes effect at the clock edge that samples it. The bench therefore reads a register at the falling edge after that edge. This applies to a read request's data, to the frozen registers and to the control bits. The write busy bit is counted over falling edges starting at the first one after the starting write, and it must hold for exactly WRITE_CYCLES of them. The flag must appear at the falling edge right after the last of those. A behavioural model runs alongside and is compared with `bus_rdata` and `done_irq` at every falling edge. This catches any result that arrives one cycle early or late.

// File: rtl/keyed_nvm_ctrl.sv
module keyed_nvm_ctrl #(
  parameter int WRITE_CYCLES = 16,
  parameter int ADDR_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       done_irq
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);
  localparam logic [7:0] KEY_A = 8'h55;
  localparam logic [7:0] KEY_B = 8'hAA;

  typedef enum logic [1:0] {K_IDLE, K_FIRST, K_ARMED} key_t;

  logic [7:0]        mem [DEPTH];
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              wr_q, wren_q, flag_q;
  key_t              key_q;

  wire sel_addr = bus_we && bus_addr == 2'd0;
  wire sel_data = bus_we && bus_addr == 2'd1;
  wire sel_ctrl = bus_we && bus_addr == 2'd2;
  wire sel_key  = bus_we && bus_addr == 2'd3;
  wire ctrl_ok  = sel_ctrl && !wr_q;
  wire start    = ctrl_ok && bus_wdata[1] && wren_q && key_q == K_ARMED;
  wire rd_go    = ctrl_ok && bus_wdata[0] && !start;
  wire done     = wr_q && cnt_q == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) key_q <= K_IDLE;
    else if (bus_we) begin
      if (sel_key && key_q == K_IDLE && bus_wdata == KEY_A) key_q <= K_FIRST;
      else if (sel_key && key_q == K_FIRST && bus_wdata == KEY_B) key_q <= K_ARMED;
      else key_q <= K_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      wr_q   <= 1'b0;
      wren_q <= 1'b0;
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (sel_addr && !wr_q) addr_q <= bus_wdata[ADDR_W-1:0];
      if (rd_go) data_q <= mem[addr_q];
      else if (sel_data && !wr_q) data_q <= bus_wdata;
      if (ctrl_ok) wren_q <= bus_wdata[2];
      if (start) begin
        wr_q  <= 1'b1;
        cnt_q <= CNT_W'(WRITE_CYCLES - 1);
      end else if (done) begin
        wr_q <= 1'b0;
      end else if (wr_q) begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (done) flag_q <= 1'b1;
      else if (ctrl_ok) flag_q <= flag_q & bus_wdata[3];
    end
  end

  always_ff @(posedge clk) if (done) mem[addr_q] <= data_q;

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = 8'(addr_q);
      2'd1:    bus_rdata = data_q;
      2'd2:    bus_rdata = {4'b0, flag_q, wren_q, wr_q, 1'b0};
      default: bus_rdata = 8'h00;
    endcase
  end
  assign done_irq = flag_q;

  // R10
  flag_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_q) |-> flag_q);
  // R10
  flag_sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(bus_we && bus_addr == 2'd2));
  // R7
  wren_sw_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wren_q) |-> $past(bus_we && bus_addr == 2'd2 && !bus_wdata[2]));
  // R4
  start_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_q) |-> $past(key_q == K_ARMED && wren_q));
  // R8
  frozen_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_q) |-> ($stable(addr_q) && $stable(data_q) && $stable(wren_q)));
endmodule

// File: tb/sim_keyed_nvm_ctrl.sv
`timescale 1ns/1ps
module sim_keyed_nvm_ctrl;
  localparam int WC = 16;
  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00, bus_rdata;
  logic done_irq;
  int checks = 0, fails = 0;

  keyed_nvm_ctrl #(.WRITE_CYCLES(WC), .ADDR_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done_irq(done_irq));

  always #10 clk = ~clk;

  // behavioural reference
  byte unsigned m_mem [256];
  int m_addr = 0, m_data = 0, m_key = 0, m_left = 0, m_wa = 0, m_wd = 0;
  bit m_busy = 0, m_wren = 0, m_flag = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_addr = 0; m_data = 0; m_key = 0; m_busy = 0; m_wren = 0; m_flag = 0; m_left = 0;
    end else begin
      bit was_busy;
      int prev_key;
      was_busy = m_busy;
      prev_key = m_key;
      if (bus_we) begin
        if (bus_addr == 3) m_key = (prev_key == 0 && bus_wdata == 8'h55) ? 1 :
                                   (prev_key == 1 && bus_wdata == 8'hAA) ? 2 : 0;
        else m_key = 0;
        if (!was_busy) begin
          if (bus_addr == 0) m_addr = bus_wdata;
          if (bus_addr == 1) m_data = bus_wdata;
          if (bus_addr == 2) begin
            if (bus_wdata[1] && m_wren && prev_key == 2) begin
              m_busy = 1; m_left = WC; m_wa = m_addr; m_wd = m_data;
            end else if (bus_wdata[0]) m_data = m_mem[m_addr];
            m_wren = bus_wdata[2];
            m_flag = m_flag & bus_wdata[3];
          end
        end
      end
      if (was_busy) begin
        m_left--;
        if (m_left == 0) begin
          m_mem[m_wa] = 8'(m_wd); m_busy = 0; m_flag = 1;
        end
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    logic [7:0] e;
    case (bus_addr)
      2'd0: e = 8'(m_addr);
      2'd1: e = 8'(m_data);
      2'd2: e = {4'b0, m_flag, m_wren, m_busy, 1'b0};
      default: e = 8'h00;
    endcase
    checks++;
    if (bus_rdata !== e) begin
      fails++;
      $display("FAIL %s model rdata off %0d: got %02h exp %02h",
               bus_addr == 2 ? "R9" : (bus_addr == 3 ? "R4" : "R8"), bus_addr, bus_rdata, e);
    end
    checks++;
    if (done_irq !== m_flag) begin
      fails++;
      $display("FAIL R10 model done_irq: got %0b exp %0b", done_irq, m_flag);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, input logic [7:0] exp, input string tag);
    bus_addr = a;
    @(negedge clk);
    checks++;
    if (bus_rdata !== exp) begin
      fails++;
      $display("FAIL %s offset %0d: got %02h exp %02h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    @(negedge clk);
    checks++;
    if (done_irq !== exp) begin
      fails++;
      $display("FAIL %s done_irq: got %0b exp %0b", tag, done_irq, exp);
    end
  endtask

  task automatic unlock();
    wr(2'd3, 8'h55);
    wr(2'd3, 8'hAA);
  endtask

  task automatic wait_done();
    bus_addr = 2'd2;
    for (int i = 0; i < 100 && bus_rdata[1]; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired: got timeout exp completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    peek(2'd0, 8'h00, "R1");
    peek(2'd1, 8'h00, "R1");
    peek(2'd2, 8'h00, "R1");
    peek(2'd3, 8'h00, "R1");
    chk_irq(1'b0, "R1");

    // first byte: exact duration
    wr(2'd0, 8'h10); wr(2'd1, 8'h3C); wr(2'd2, 8'h04);
    unlock();
    wr(2'd2, 8'h06);
    begin
      int n = 0;
      bus_addr = 2'd2;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (bus_rdata[1]) n++;
        else break;
      end
      checks++;
      if (n != WC) begin
        fails++;
        $display("FAIL R9 busy length: got %0d exp %0d", n, WC);
      end
    end
    chk_irq(1'b1, "R10");
    peek(2'd2, 8'h0C, "R7");
    repeat (5) @(negedge clk);
    chk_irq(1'b1, "R10");

    // read back
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h0D);
    peek(2'd1, 8'h3C, "R2");
    peek(2'd2, 8'h0C, "R2");
    wr(2'd0, 8'h20);
    peek(2'd1, 8'h3C, "R3");
    wr(2'd1, 8'h99);
    peek(2'd1, 8'h99, "R3");
    wr(2'd2, 8'h04);
    chk_irq(1'b0, "R10");

    // second byte with frozen registers
    unlock();
    wr(2'd2, 8'h06);
    wr(2'd0, 8'h77);
    peek(2'd0, 8'h20, "R8");
    wr(2'd1, 8'h11);
    peek(2'd1, 8'h99, "R8");
    wr(2'd2, 8'h01);
    peek(2'd1, 8'h99, "R8");
    peek(2'd2, 8'h06, "R8");
    wait_done();
    peek(2'd2, 8'h0C, "R10");
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h0D);
    peek(2'd1, 8'h99, "R9");
    wr(2'd0, 8'h10);
    wr(2'd2, 8'h05);
    peek(2'd1, 8'h3C, "R9");
    chk_irq(1'b0, "R10");

    // enable rules
    wr(2'd2, 8'h00);
    unlock();
    wr(2'd2, 8'h06);
    peek(2'd2, 8'h04, "R6");
    wr(2'd2, 8'h06);
    peek(2'd2, 8'h04, "R4");
    wr(2'd2, 8'h00);
    unlock();
    wr(2'd2, 8'h02);
    peek(2'd2, 8'h00, "R6");

    // cancelled sequences
    wr(2'd2, 8'h04);
    wr(2'd3, 8'h55); wr(2'd3, 8'hAB); wr(2'd3, 8'hAA);
    wr(2'd2, 8'h06);
    peek(2'd2, 8'h04, "R5");
    wr(2'd3, 8'h55); wr(2'd0, 8'h30); wr(2'd3, 8'hAA);
    wr(2'd2, 8'h06);
    peek(2'd2, 8'h04, "R5");
    peek(2'd3, 8'h00, "R4");
    wr(2'd1, 8'h5E);
    unlock();
    wr(2'd2, 8'h06);
    peek(2'd2, 8'h06, "R4");
    wait_done();
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h05);
    peek(2'd1, 8'h5E, "R9");
    peek(2'd2, 8'h04, "R7");

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule